// File: doc/BRIEF.md
# Echo Canceller Anti-Howling Controller

This block post-processes the linear sample streams that surround an echo canceller, sample by sample. It takes the receive-in sample, the send-in sample (before cancellation) and the send-out sample (after cancellation). It returns a processed receive-out sample and a processed send-out sample. Each path gets a level estimate, and a double-talk decision comes from those estimates. The decision puts roughly 6 dB of loss on the send output or on the receive path. An optional center clipper forces near-silent send output to the smallest positive code. An optional automatic gain stage lowers the receive level in half-decibel steps once that path gets loud. A through mode hands send-in and receive-in straight to the outputs.

Samples travel as one bundle on a valid/ready stream. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result is registered and is presented on the next cycle. The block is ready whenever its output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output bundle is held unchanged and no new input is taken. Each accepted bundle counts as one 8 kHz sample for all internal timing.

Top module: `howl_guard`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or is being read. A bundle accepted on an edge appears on the outputs, with `out_valid` high, right after that edge. While `out_valid=1` and `out_ready=0`, `out_valid`, `rout_o` and `sout_o` stay constant.
- R2: Each of the receive-in and send-in paths has an envelope E, zero after reset. On every accepted sample, E becomes max(|x|, E - (E >> 4)). The path counts as active for that sample when this new E is greater than or equal to its threshold port.
- R3: When receive-in is active and send-in is not, and `att_off_i=0`, the send-out value is arithmetically shifted right by one bit (about 6 dB loss).
- R4: When send-in is active, with or without receive-in activity, and `att_off_i=0`, the receive-out value is arithmetically shifted right by one bit instead. The send path gets no loss.
- R5: After the last active sample, the loss decision stays in force for 256 further samples (32 ms). On the next sample it is released and no loss is applied. New activity re-decides the loss at once.
- R6: With `att_off_i=1` no attenuation is applied to either path, whatever the decision.
- R7: With `clip_en_i=1`, a send-out value whose magnitude is 16 or less after attenuation is replaced by +1.
- R8: With `agc_en_i=1`, receive-out is floor(rin × C / 32768), where C = round(32768 × 10^(-k/40)) and the step k is 0..17 (0.5 dB per step, at most 8.5 dB). Every 8th accepted sample, k moves one step. It rises if the receive envelope is at least 2068 (about -24 dBm0) and falls otherwise, saturating at 17 and 0. The new k applies from the following sample.
- R9: With `agc_en_i=0`, the step returns to 0 and the receive path has unity gain.
- R10: With `thru_i=1`, `sout_o` equals send-in and `rout_o` equals receive-in, unchanged. The level estimates, the decision and the gain step keep updating.
- R11: After reset, `out_valid` is low, `in_ready` is high, the gain step is 0 and no loss is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample bundle valid |
| in_ready | output | 1 | Block can accept a bundle |
| rin_i | input | 16 | Receive-in sample, signed |
| sin_i | input | 16 | Send-in sample (before cancellation), signed |
| sout_i | input | 16 | Send-out sample (after cancellation), signed |
| out_valid | output | 1 | Output bundle valid |
| out_ready | input | 1 | Consumer takes the output bundle |
| rout_o | output | 16 | Processed receive-out sample, signed |
| sout_o | output | 16 | Processed send-out sample, signed |
| thru_i | input | 1 | Through mode |
| att_off_i | input | 1 | 1 disables the 6 dB attenuator |
| clip_en_i | input | 1 | Center clipper enable |
| agc_en_i | input | 1 | Receive gain stage enable |
| rin_thr_i | input | 16 | Receive-in activity threshold |
| sin_thr_i | input | 16 | Send-in activity threshold |

## Verification
The output value for a bundle is due one clock after its accepting edge. The bench drives on the falling edge and compares on the next falling edge, half a cycle after the register has loaded. Decisions that span samples are counted in accepted bundles, not in cycles: the hangover releases on the 257th quiet sample, and a gain step change shows on the sample after every 8th. The bench model advances once per accepted bundle so the two line up. In the stall test the held output is compared on several consecutive cycles while `out_ready` is low. The next bundle is then checked on the cycle after the release.

// File: rtl/howl_pkg.sv
package howl_pkg;

  typedef enum logic [1:0] {
    LOSS_NONE = 2'd0,
    LOSS_SEND = 2'd1,
    LOSS_RECV = 2'd2
  } loss_e;

  // Q15 gain for k half-decibel steps of attenuation (k = 0..17)
  function automatic logic [16:0] step_coef(input logic [4:0] k);
    logic [16:0] c;
    case (k)
      5'd0:  c = 17'd32768;
      5'd1:  c = 17'd30935;
      5'd2:  c = 17'd29205;
      5'd3:  c = 17'd27571;
      5'd4:  c = 17'd26029;
      5'd5:  c = 17'd24573;
      5'd6:  c = 17'd23198;
      5'd7:  c = 17'd21900;
      5'd8:  c = 17'd20675;
      5'd9:  c = 17'd19519;
      5'd10: c = 17'd18427;
      5'd11: c = 17'd17396;
      5'd12: c = 17'd16423;
      5'd13: c = 17'd15504;
      5'd14: c = 17'd14637;
      5'd15: c = 17'd13818;
      5'd16: c = 17'd13045;
      default: c = 17'd12315;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/howl_env.sv
module howl_env #(
  parameter int W        = 16,
  parameter int DECAY_SH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic signed [W-1:0] x,
  input  logic        [W-1:0] thr,
  output logic        [W-1:0] env_o,
  output logic                act_o
);
  logic [W-1:0] env_q, mag, dec;

  always_comb begin
    mag   = x[W-1] ? W'(-x) : W'(x);
    dec   = env_q - (env_q >> DECAY_SH);
    env_o = (mag > dec) ? mag : dec;
    act_o = (env_o >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   env_q <= '0;
    else if (upd) env_q <= env_o;
  end
endmodule

// File: rtl/howl_dt.sv
module howl_dt
  import howl_pkg::*;
#(
  parameter int HANG = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd,
  input  logic  rin_act,
  input  logic  sin_act,
  output loss_e mode_o
);
  localparam int CW = $clog2(HANG + 1);

  loss_e         mode_q;
  logic [CW-1:0] hang_q;

  always_comb begin
    if (sin_act)            mode_o = LOSS_RECV;
    else if (rin_act)       mode_o = LOSS_SEND;
    else if (hang_q != '0)  mode_o = mode_q;
    else                    mode_o = LOSS_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LOSS_NONE;
      hang_q <= '0;
    end else if (upd) begin
      mode_q <= mode_o;
      if (sin_act || rin_act) hang_q <= CW'(HANG);
      else if (hang_q != '0)  hang_q <= hang_q - 1'b1;
    end
  end
endmodule

// File: rtl/howl_agc.sv
module howl_agc
  import howl_pkg::*;
#(
  parameter int W        = 16,
  parameter int STEP_MAX = 17,
  parameter int TICK     = 8,
  parameter int KNEE     = 2068
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic                en,
  input  logic        [W-1:0] env,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);
  localparam int CF = 17;          // coefficient width, Q15 with unity
  localparam int PW = W + CF;      // product width
  localparam int TW = (TICK > 1) ? $clog2(TICK) : 1;

  logic [4:0]          step_q;
  logic [TW-1:0]       tick_q;
  logic                tick;
  logic [CF-1:0]       coef;
  logic signed [PW-1:0] xs;
  logic signed [PW-1:0] pp [CF];
  logic signed [PW-1:0] acc;

  assign tick = (tick_q == TW'(TICK - 1));
  assign coef = step_coef(step_q);
  assign xs   = {{(PW-W){x[W-1]}}, x};

  // shift-and-add multiply: one partial product per coefficient bit
  for (genvar b = 0; b < CF; b++) begin : g_pp
    assign pp[b] = coef[b] ? (xs <<< b) : '0;
  end

  always_comb begin
    acc = '0;
    for (int b = 0; b < CF; b++) acc = acc + pp[b];
    y = en ? acc[W+14:15] : x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      tick_q <= '0;
    end else begin
      if (upd) tick_q <= tick ? '0 : tick_q + 1'b1;
      if (!en) step_q <= '0;
      else if (upd && tick) begin
        if (env >= W'(KNEE)) begin
          if (step_q < 5'(STEP_MAX)) step_q <= step_q + 1'b1;
        end else if (step_q != '0) begin
          step_q <= step_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/howl_guard.sv
module howl_guard
  import howl_pkg::*;
#(
  parameter int W        = 16,
  parameter int DECAY_SH = 4,
  parameter int HANG     = 256,
  parameter int TICK     = 8,
  parameter int STEP_MAX = 17,
  parameter int KNEE     = 2068,
  parameter int CLIP_LVL = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] rin_i,
  input  logic signed [W-1:0] sin_i,
  input  logic signed [W-1:0] sout_i,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] rout_o,
  output logic signed [W-1:0] sout_o,
  input  logic                thru_i,
  input  logic                att_off_i,
  input  logic                clip_en_i,
  input  logic                agc_en_i,
  input  logic        [W-1:0] rin_thr_i,
  input  logic        [W-1:0] sin_thr_i
);
  localparam logic signed [W-1:0] CLIP_HI = W'(CLIP_LVL);
  localparam logic signed [W-1:0] CLIP_LO = W'(-CLIP_LVL);

  logic                accept;
  logic        [W-1:0] renv, senv;
  logic                ract, sact;
  loss_e               mode;
  logic signed [W-1:0] rgain, rproc, satt, sproc;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  howl_env #(.W(W), .DECAY_SH(DECAY_SH)) u_env_r (
    .clk(clk), .rst_n(rst_n), .upd(accept), .x(rin_i), .thr(rin_thr_i),
    .env_o(renv), .act_o(ract));

  howl_env #(.W(W), .DECAY_SH(DECAY_SH)) u_env_s (
    .clk(clk), .rst_n(rst_n), .upd(accept), .x(sin_i), .thr(sin_thr_i),
    .env_o(senv), .act_o(sact));

  howl_dt #(.HANG(HANG)) u_dt (
    .clk(clk), .rst_n(rst_n), .upd(accept), .rin_act(ract), .sin_act(sact),
    .mode_o(mode));

  howl_agc #(.W(W), .STEP_MAX(STEP_MAX), .TICK(TICK), .KNEE(KNEE)) u_agc (
    .clk(clk), .rst_n(rst_n), .upd(accept), .en(agc_en_i), .env(renv),
    .x(rin_i), .y(rgain));

  always_comb begin
    rproc = (mode == LOSS_RECV && !att_off_i) ? (rgain >>> 1) : rgain;
    satt  = (mode == LOSS_SEND && !att_off_i) ? (sout_i >>> 1) : sout_i;
    sproc = (clip_en_i && satt <= CLIP_HI && sat_ge(satt)) ? W'(1) : satt;
  end

  function automatic logic sat_ge(input logic signed [W-1:0] v);
    return v >= CLIP_LO;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rout_o    <= '0;
      sout_o    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      rout_o    <= thru_i ? rin_i : rproc;
      sout_o    <= thru_i ? sin_i : sproc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/howl_guard_chk.sv
module howl_guard_chk #(
  parameter int W        = 16,
  parameter int CLIP_LVL = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic signed [W-1:0] rin_i,
  input logic signed [W-1:0] sin_i,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [W-1:0] rout_o,
  input logic signed [W-1:0] sout_o,
  input logic                thru_i,
  input logic                att_off_i,
  input logic                clip_en_i,
  input logic                agc_en_i
);
  logic take;
  assign take = in_valid && in_ready;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(rout_o) && $stable(sout_o)); // R1

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R1

  AST_THRU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take && thru_i |=> rout_o == $past(rin_i) && sout_o == $past(sin_i)); // R10

  AST_ATT_OFF_RX: assert property (@(posedge clk) disable iff (!rst_n)
    take && !thru_i && att_off_i && !agc_en_i |=> rout_o == $past(rin_i)); // R6

  AST_CLIP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    take && !thru_i && clip_en_i |=>
      (sout_o == W'(1) || int'(sout_o) > CLIP_LVL || int'(sout_o) < -CLIP_LVL)); // R7
endmodule

bind howl_guard howl_guard_chk #(.W(W), .CLIP_LVL(CLIP_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rin_i(rin_i), .sin_i(sin_i), .out_valid(out_valid), .out_ready(out_ready),
  .rout_o(rout_o), .sout_o(sout_o), .thru_i(thru_i), .att_off_i(att_off_i),
  .clip_en_i(clip_en_i), .agc_en_i(agc_en_i));

// File: tb/howl_guard_tb.sv
module howl_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic signed [15:0] rin = 0, sin = 0, sout = 0, rout_o, sout_o;
  logic thru = 0, att_off = 0, clip_en = 0, agc_en = 0;
  logic [15:0] rthr = 16'd1000, sthr = 16'd1000;

  howl_guard u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rin_i(rin), .sin_i(sin), .sout_i(sout), .out_valid(out_valid),
    .out_ready(out_ready), .rout_o(rout_o), .sout_o(sout_o), .thru_i(thru),
    .att_off_i(att_off), .clip_en_i(clip_en), .agc_en_i(agc_en),
    .rin_thr_i(rthr), .sin_thr_i(sthr));

  int n_chk = 0, n_bad = 0;

  // reference state, advanced once per accepted bundle
  int m_er = 0, m_es = 0, m_mode = 0, m_hang = 0, m_step = 0, m_cnt = 0;

  task automatic chk(input string tag, input int act, input int exp, input int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d > tol || d < -tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int envn(input int e, input int x);
    int a, dec;
    a = (x < 0) ? -x : x;
    dec = e - (e >> 4);
    return (a > dec) ? a : dec;
  endfunction

  task automatic model(input int r, input int s, input int so,
                       output int er, output int es, output int tol);
    int nr, ns, coef, g, sx;
    bit ra, sa;
    nr = envn(m_er, r); ns = envn(m_es, s);
    ra = nr >= int'(rthr); sa = ns >= int'(sthr);
    if (sa) begin m_mode = 2; m_hang = 256; end       // R4
    else if (ra) begin m_mode = 1; m_hang = 256; end  // R3
    else if (m_hang > 0) m_hang--;                    // R5
    else m_mode = 0;
    coef = $rtoi(32768.0 * (10.0 ** (-m_step / 40.0)) + 0.5);  // R8
    g = agc_en ? ((r * coef) >>> 15) : r;
    tol = (agc_en && m_step > 0) ? 1 : 0;
    er = (m_mode == 2 && !att_off) ? (g >>> 1) : g;
    sx = (m_mode == 1 && !att_off) ? (so >>> 1) : so;
    if (clip_en && sx <= 16 && sx >= -16) sx = 1;     // R7
    es = sx;
    if (thru) begin er = r; es = s; tol = 0; end      // R10
    if (!agc_en) m_step = 0;                          // R9
    else if (m_cnt == 7) begin
      if (nr >= 2068) begin if (m_step < 17) m_step++; end
      else if (m_step > 0) m_step--;
    end
    m_cnt = (m_cnt + 1) % 8;
    m_er = nr; m_es = ns;
  endtask

  task automatic push(input string tag, input int r, input int s, input int so);
    int er, es, tol;
    model(r, s, so, er, es, tol);
    @(negedge clk);
    rin = 16'(r); sin = 16'(s); sout = 16'(so); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " valid"}, int'(out_valid), 1, 0);
    chk({tag, " rout"}, int'(rout_o), er, tol);
    chk({tag, " sout"}, int'(sout_o), es, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ea, esa, ta, eb, esb, tb;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", int'(out_valid), 0, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 in_ready after reset", int'(in_ready), 1, 0);
    chk("R11 out_valid after reset", int'(out_valid), 0, 0);

    // R2 quiet sweep: below both thresholds, no loss anywhere
    for (int v = -500; v <= 500; v += 50) push("R2 quiet", v, -v, v + 3);

    // R3 receive-only activity: send-out halved, odd and negative values
    for (int v = -41; v <= 41; v += 7) push("R3 rx only", 20000, 0, v * 101);

    // R5 hangover: silence for longer than 256 samples
    for (int i = 0; i < 300; i++) push("R5 hangover", 0, 0, 777 - i);

    // R4 send-in active alone, then both active
    for (int v = -3001; v <= 3001; v += 1000) push("R4 tx only", v, 12000, 901);
    for (int v = -3001; v <= 3001; v += 1000) push("R4 both", 15000, 12000 + v, 901);
    for (int i = 0; i < 270; i++) push("R5 release rx", 333, 0, -555);

    // R6 attenuator disabled while both paths are loud
    att_off = 1;
    for (int v = -9; v <= 9; v += 3) push("R6 att off", 9000 + v, 9000, v * 77);
    att_off = 0;

    // R7 clipper sweep, with and without send attenuation
    clip_en = 1;
    for (int v = -40; v <= 40; v++) push("R7 clip", 0, 0, v);
    for (int v = -40; v <= 40; v += 3) push("R7 clip att", 20000, 0, v);
    clip_en = 0;
    for (int i = 0; i < 270; i++) push("R5 settle", 0, 0, 1);

    // R8 gain ramp up to the 8.5 dB limit, then back down
    agc_en = 1;
    for (int i = 0; i < 160; i++) push("R8 ramp up", (i % 2) ? 10000 : -9999, 0, 0);
    for (int i = 0; i < 200; i++) push("R8 ramp down", 700 - i, 0, 0);
    for (int i = 0; i < 40; i++) push("R8 mid", 4000, 0, 0);

    // R9 disable: unity gain immediately
    agc_en = 0;
    for (int v = -30000; v <= 30000; v += 7500) push("R9 agc off", v, 0, 0);

    // R10 through mode
    thru = 1; clip_en = 1; agc_en = 1;
    for (int v = -32768; v <= 32767; v += 4681) push("R10 thru", v, -v - 1, 5);
    thru = 0; clip_en = 0; agc_en = 0;

    // R1 back-pressure: hold output while stalled, then take the next bundle
    @(negedge clk);
    model(1234, 0, 4321, ea, esa, ta);
    rin = 16'sd1234; sin = 0; sout = 16'sd4321; in_valid = 1; out_ready = 0;
    chk("R1 ready when empty", int'(in_ready), 1, 0);
    @(negedge clk);
    chk("R1 valid after accept", int'(out_valid), 1, 0);
    chk("R1 not ready when stalled", int'(in_ready), 0, 0);
    rin = -16'sd2222; sout = -16'sd3333;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 held valid", int'(out_valid), 1, 0);
      chk("R1 held rout", int'(rout_o), ea, ta);
      chk("R1 held sout", int'(sout_o), esa, 0);
    end
    model(-2222, 0, -3333, eb, esb, tb);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R1 next rout", int'(rout_o), eb, tb);
    chk("R1 next sout", int'(sout_o), esb, 0);
    @(negedge clk);
    chk("R1 drained", int'(out_valid), 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule